// File: doc/BRIEF.md
# Precharged Two-Stage Row Decoder

This block selects one word line out of 128 in a memory array. It works in two phases. While the active-low precharge strobe is low, every select line is forced to its inactive high level. When the strobe is released, the row field of the incoming address is captured, and the one matching select line is pulled low. The other 127 lines stay high. Downstream drivers read these logic-level selects. Analog levels and transistor sizing are outside this model.

Decoding is done in two stages instead of one flat decoder. The low three row bits go to a predecoder that drives 8 one-hot lines. The upper four row bits go to a predecoder that drives 16 one-hot lines. A final array of 2-input AND terms pairs one line from each group, giving 8 x 16 = 128 outputs. The predecoded lines are registered at the start of evaluate, so the selection stays fixed until the next precharge.

Top module: `rowdec_top`

## Requirements
- R1: While `rst_n` is low, all 128 bits of `wl_n` are 1.
- R2: In any cycle where `pre_n` is 0, all bits of `wl_n` are 1, with no clock edge needed.
- R3: Take a rising clock edge that samples `pre_n` = 1 when the previous sample was 0, or the first such edge after reset. From the next sample point on, for as long as `pre_n` stays 1, exactly one bit of `wl_n` is 0.
- R4: The low bit has index r, where r = `addr[13:7]` read as an unsigned number, as captured at the edge named in R3. So row 0 drives `wl_n[0]` low, rows 1 to 3 drive bits 1 to 3 low, and so on.
- R5: Address bits 6 down to 0 have no effect on which line is selected.
- R6: Changes on `addr` after the capture edge, while `pre_n` stays 1, leave `wl_n` unchanged.
- R7: Both ends of the 3-bit group decode correctly. A low group of all ones selects an output whose index ends in 111b, such as 7 or 127. The all-ones row 127 selects `wl_n[127]`. Row 120 has a low group of 000 and an upper group of 1111, and it selects `wl_n[120]`.
- R8: A new precharge after an evaluate returns every line high. The following evaluate captures the new row, with no trace of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the capture of the row field happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_n | input | 1 | Active-low precharge strobe; high means evaluate |
| addr | input | 14 | Full address; bits 13:7 form the row number |
| wl_n | output | 128 | Active-low word-line selects, bit r for row r |

## Verification
A wrong predecoded register in this block does not stay hidden. A missing one-hot bit shows up as no low line at all. An extra bit shows up as two or more low lines. A swapped bit shows up as the wrong index. Each of these appears at the first sample point after the capture edge and persists for the whole evaluate phase. A fault in the phase state shows up either as a line falling during precharge or as a selection that moves when the address changes mid-evaluate.

Sweeping all 128 rows, with the ignored low bits scrambled and a new address applied during every evaluate, makes each such fault visible within one cycle of the row it corrupts.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_EVALUATE  = 1'b1
    } rowdec_phase_e;

endpackage

// File: rtl/rowdec_predecode.sv
module rowdec_predecode #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]      code,
    output logic [(1<<IN_W)-1:0] line
);
    localparam int LINES = 1 << IN_W;

    // one comparator per line; each line rises for exactly one code
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line[i] = (code == IN_W'(i));
    end

endmodule

// File: rtl/rowdec_combine.sv
module rowdec_combine #(
    parameter int LO_N = 8,
    parameter int HI_N = 16
) (
    input  logic                   eval_en,
    input  logic [LO_N-1:0]        lo_line,
    input  logic [HI_N-1:0]        hi_line,
    output logic [LO_N*HI_N-1:0]   wl_n
);
    // each output discharges only when evaluate is on and its two terms meet
    for (genvar h = 0; h < HI_N; h++) begin : g_hi
        for (genvar l = 0; l < LO_N; l++) begin : g_lo
            assign wl_n[h*LO_N + l] = ~(eval_en & lo_line[l] & hi_line[h]);
        end
    end

endmodule

// File: rtl/rowdec_top.sv
module rowdec_top #(
    parameter int ADDR_W  = 14,
    parameter int ROW_LSB = 7,
    parameter int LO_BITS = 3,
    parameter int HI_BITS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pre_n,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [(1<<(LO_BITS+HI_BITS))-1:0]    wl_n
);
    import rowdec_pkg::*;

    localparam int ROW_BITS = LO_BITS + HI_BITS;
    localparam int LO_N     = 1 << LO_BITS;
    localparam int HI_N     = 1 << HI_BITS;
    localparam int ROWS     = LO_N * HI_N;

    typedef struct packed {
        rowdec_phase_e   phase;
        logic [LO_N-1:0] lo_line;
        logic [HI_N-1:0] hi_line;
    } rowdec_state_t;

    rowdec_state_t state_d, state_q;

    logic [ROW_BITS-1:0] row_field;
    logic [LO_N-1:0]     lo_dec;
    logic [HI_N-1:0]     hi_dec;
    logic                eval_en;
    logic                unused_addr_bits;

    assign row_field        = addr[ROW_LSB +: ROW_BITS];
    assign unused_addr_bits = ^addr;

    rowdec_predecode #(.IN_W(LO_BITS)) i_pre_lo (
        .code (row_field[LO_BITS-1:0]),
        .line (lo_dec)
    );

    rowdec_predecode #(.IN_W(HI_BITS)) i_pre_hi (
        .code (row_field[ROW_BITS-1:LO_BITS]),
        .line (hi_dec)
    );

    always_comb begin
        state_d = state_q;
        if (pre_n) begin
            state_d.phase = PH_EVALUATE;
            if (state_q.phase == PH_PRECHARGE) begin
                state_d.lo_line = lo_dec;
                state_d.hi_line = hi_dec;
            end
        end else begin
            state_d.phase = PH_PRECHARGE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign eval_en = pre_n && (state_q.phase == PH_EVALUATE);

    rowdec_combine #(.LO_N(LO_N), .HI_N(HI_N)) i_combine (
        .eval_en (eval_en),
        .lo_line (state_q.lo_line),
        .hi_line (state_q.hi_line),
        .wl_n    (wl_n)
    );

    AST_PRECHARGE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !pre_n |-> (&wl_n)); // R2
    AST_EVAL_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (pre_n && state_q.phase == PH_EVALUATE) |-> ($countones(~wl_n) == 1)); // R3
    AST_EVAL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (pre_n && state_q.phase == PH_EVALUATE && $past(state_q.phase == PH_EVALUATE)) |-> $stable(wl_n)); // R6
    AST_NEW_PRECHARGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(pre_n) |-> (&wl_n)); // R8
    AST_RELEASE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (pre_n && state_q.phase == PH_PRECHARGE) |-> (&wl_n)); // R3
    AST_PREDECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) ($countones(lo_dec) == 1) && ($countones(hi_dec) == 1)); // R7

endmodule

// File: tb/test_rowdec_top.sv
`timescale 1ns/100ps
module test_rowdec_top;
    localparam int ROWS = 128;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pre_n = 1'b1;
    logic [13:0]      addr = '0;
    logic [ROWS-1:0]  wl_n;

    int total = 0;
    int bad   = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    rowdec_top i_rowdec_top (
        .clk   (clk),
        .rst_n (rst_n),
        .pre_n (pre_n),
        .addr  (addr),
        .wl_n  (wl_n)
    );

    function automatic logic [ROWS-1:0] expect_vec(int r);
        logic [ROWS-1:0] v;
        v = '1;
        v[r] = 1'b0;
        return v;
    endfunction

    task automatic check_high(string tag);
        total++;
        if (wl_n !== {ROWS{1'b1}}) begin
            bad++;
            $display("FAIL %s: wl_n=%h expected all ones", tag, wl_n);
        end
    endtask

    // monitor: compares against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            int r;
            r = exp_q.pop_front();
            total++;
            if (wl_n !== expect_vec(r) || $countones(~wl_n) != 1) begin
                bad++;
                $display("FAIL R3 R4 R5 R6: row %0d wl_n=%h expected %h", r, wl_n, expect_vec(r));
            end
        end
    end

    // driver: one precharge/evaluate round for row r, scrambled low bits
    task automatic run_row(int r, logic [6:0] junk);
        @(posedge clk); #1;
        pre_n = 1'b0;
        addr  = {7'(r), junk};
        #0.5 check_high("R2 R8 precharge");
        @(posedge clk); #1;
        pre_n = 1'b1;
        #0.5 check_high("R3 before capture");
        @(posedge clk); #1;
        exp_q.push_back(r);
        addr = {7'(r) ^ 7'h2A, ~junk};
        @(posedge clk); #1;
        exp_q.push_back(r);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check_high("R1 reset");
        rst_n = 1'b1;
        // R7 corner rows first
        run_row(7, 7'h7F);
        run_row(127, 7'h00);
        run_row(120, 7'h55);
        run_row(0, 7'h7F);
        // R4 R5 full sweep with varying ignored bits
        for (int r = 0; r < ROWS; r++) begin
            run_row(r, 7'((r * 37 + 11) % 128));
        end
        // R8 back-to-back rows differing in every bit
        run_row(85, 7'h12);
        run_row(42, 7'h6D);
        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule